// File: doc/BRIEF.md
# Transaction Commit-Order Dependence Tracker

This block orders the commits of up to four concurrently running hardware transactions. A conflict between two transactions does not abort either of them. The block turns each conflict into an ordering edge instead: the edge's source must commit before its destination. A transaction that asks to commit is granted only once every transaction it is ordered behind has left. When a transaction received speculative data from another one, an abort of the supplier spreads to the receiver. That spread also follows longer chains of such data passing.

The graph is kept conservatively as a linear list of slot IDs in the order the transactions began. A new edge whose destination already sits ahead of its source in that list would contradict the list. The block treats such an edge as a cycle: it raises a flag, names the later-positioned transaction (the source) as the victim and aborts it, together with everything that consumed its data. Slot IDs are the transaction IDs, and each slot holds a bitmask of predecessors that have not yet committed.

All results are registered. A stimulus applied before a rising clock edge shows on the outputs right after that edge.

Top module: `txn_order_tracker`

## Requirements
- R1: After reset no slot is live and every output is zero. A commit request on a slot that is not live yields neither grant nor stall.
- R2: A begin on a free slot makes it live and appends it at the tail of the order list. A begin on a slot that is already live is ignored and leaves its position unchanged.
- R3: A commit request from a live slot with no outstanding predecessor produces a one-cycle grant on the next edge. The slot then becomes free.
- R4: A live slot that requests commit while a predecessor has not committed gets its stall bit set and no grant. Its grant follows in the cycle after the last predecessor commits.
- R5: Conflict kind 0 (read then write) and kind 2 (write then write) order the source before the destination. An abort of the source frees the destination to commit but does not abort it.
- R6: Conflict kind 1 (write then read, data passed from source to destination) also orders the source first. Any abort of the source aborts the destination, transitively along chains of such edges, in the same cycle.
- R7: An overwrite event for a producer aborts every transaction that received data from it (and their receivers). The producer itself stays live.
- R8: A conflict whose destination already precedes its source in the order list raises the cycle flag for one cycle and reports the source as victim. The victim and its receivers are aborted and the edge is not recorded.
- R9: A conflict is ignored when either slot is not live, when source equals destination, or when its kind is the reserved value 3.
- R10: A commit request is not granted in a cycle in which the same slot is aborted or is the destination of a newly accepted conflict. The grant and abort vectors never overlap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| beg_vld | input | 1 | Transaction begin event |
| beg_id | input | 2 | Slot that begins |
| cfl_vld | input | 1 | Conflict event |
| cfl_src | input | 2 | Slot that must commit first |
| cfl_dst | input | 2 | Slot that must commit later |
| cfl_kind | input | 2 | 0 read-write, 1 write-read (data passed), 2 write-write, 3 reserved |
| ovw_vld | input | 1 | Producer rewrote data it had passed on |
| ovw_id | input | 2 | Producer slot of the overwrite |
| abt_vld | input | 1 | External abort event |
| abt_id | input | 2 | Slot to abort |
| creq | input | 4 | Per-slot commit request, level |
| grant | output | 4 | Per-slot commit grant, one-cycle pulse |
| stall | output | 4 | Per-slot commit stalled this cycle |
| kill | output | 4 | Per-slot abort vector including cascades |
| cyc_flag | output | 1 | Cycle detected, one-cycle pulse |
| cyc_victim | output | 2 | Slot restarted to break the cycle |

## Verification
Every result of this block (grant, stall, kill, cycle flag and victim) is due exactly one rising edge after the inputs that cause it. The bench drives inputs on the falling edge and steps to the next falling edge before it compares, so each check reads the outputs of the single edge that sampled its stimulus. Follow-on effects, such as a stalled slot being granted after its predecessor leaves, are checked one step later. Effects that should be ignored are checked the same way, through a later commit request, the cycle flag or the kill vector.

// File: rtl/tdt_pkg.sv
package tdt_pkg;

  typedef enum logic [1:0] {
    CK_RD_WR = 2'd0,
    CK_WR_RD = 2'd1,
    CK_WR_WR = 2'd2,
    CK_RSVD  = 2'd3
  } conf_kind_e;

endpackage

// File: rtl/tdt_cascade.sv
module tdt_cascade #(
  parameter int N = 4
) (
  input  logic [N-1:0]         seed,
  input  logic [N-1:0][N-1:0]  fwd,     // fwd[c][p]: consumer c took data from producer p
  output logic [N-1:0]         doomed
);

  // transitive closure of the abort set along data-passing edges
  function automatic logic [N-1:0] spread(input logic [N-1:0] s,
                                          input logic [N-1:0][N-1:0] f);
    logic [N-1:0] cur;
    cur = s;
    for (int pass = 0; pass < N; pass++) begin
      for (int c = 0; c < N; c++) begin
        if (|(f[c] & cur)) cur[c] = 1'b1;
      end
    end
    return cur;
  endfunction

  always_comb doomed = spread(seed, fwd);

endmodule

// File: rtl/tdt_order.sv
module tdt_order #(
  parameter int N  = 4,
  parameter int IW = $clog2(N),
  parameter int CW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  drop,
  input  logic          add_vld,
  input  logic [IW-1:0] add_id,
  input  logic [IW-1:0] qa,
  input  logic [IW-1:0] qb,
  output logic          a_first,
  output logic [N-1:0]  occ
);

  logic [N-1:0][IW-1:0] ent_q, ent_d;
  logic [CW-1:0]        len_q, len_d;

  function automatic logic [CW-1:0] rank_of(input logic [N-1:0][IW-1:0] ents,
                                            input logic [CW-1:0] len,
                                            input logic [IW-1:0] id);
    logic [CW-1:0] r;
    r = CW'(N);
    for (int p = 0; p < N; p++) begin
      if (CW'(p) < len && ents[p] == id && r == CW'(N)) r = CW'(p);
    end
    return r;
  endfunction

  always_comb a_first = rank_of(ent_q, len_q, qa) < rank_of(ent_q, len_q, qb);

  // compact out leaving slots, keep survivors in order, then append
  always_comb begin
    ent_d = ent_q;
    len_d = '0;
    for (int p = 0; p < N; p++) begin
      if (CW'(p) < len_q && !drop[ent_q[p]]) begin
        for (int q = 0; q < N; q++) begin
          if (CW'(q) == len_d) ent_d[q] = ent_q[p];
        end
        len_d = len_d + 1'b1;
      end
    end
    if (add_vld && len_d < CW'(N)) begin
      for (int q = 0; q < N; q++) begin
        if (CW'(q) == len_d) ent_d[q] = add_id;
      end
      len_d = len_d + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_q <= '0;
      len_q <= '0;
    end else begin
      ent_q <= ent_d;
      len_q <= len_d;
    end
  end

  always_comb begin
    occ = '0;
    for (int p = 0; p < N; p++) begin
      if (CW'(p) < len_q) occ[ent_q[p]] = 1'b1;
    end
  end

  // R2: each listed slot appears once
  a_r2_no_dup_entries: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(occ) == int'(len_q));

endmodule

// File: rtl/tdt_graph.sv
module tdt_graph
  import tdt_pkg::*;
#(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beg_vld,
  input  logic [IW-1:0] beg_id,
  input  logic          cfl_vld,
  input  logic [IW-1:0] cfl_src,
  input  logic [IW-1:0] cfl_dst,
  input  logic [1:0]    cfl_kind,
  input  logic          ovw_vld,
  input  logic [IW-1:0] ovw_id,
  input  logic          abt_vld,
  input  logic [IW-1:0] abt_id,
  input  logic [N-1:0]  creq,
  input  logic          src_first,
  output logic [N-1:0]  leave,
  output logic          join_vld,
  output logic [N-1:0]  live_o,
  output logic [N-1:0]  grant_o,
  output logic [N-1:0]  stall_o,
  output logic [N-1:0]  kill_o,
  output logic          cyc_o,
  output logic [IW-1:0] victim_o
);

  logic [N-1:0]         live_q, live_d;
  logic [N-1:0][N-1:0]  dep_q, dep_d;   // dep[i][j]: i waits for j
  logic [N-1:0][N-1:0]  fwd_q, fwd_d;   // fwd[i][j]: i received data from j
  logic [N-1:0][N-1:0]  fwd_eff;

  conf_kind_e kind;
  logic       cfl_ok, cyc_hit, edge_add, fwd_add;
  logic [N-1:0] seed, doomed, kill_c, commit_c, stall_c, blk, pending;

  function automatic logic [N-1:0] onehot(input logic [IW-1:0] id);
    return N'(1) << id;
  endfunction

  function automatic logic [N-1:0] column(input logic [N-1:0][N-1:0] m,
                                          input logic [IW-1:0] id);
    logic [N-1:0] c;
    for (int i = 0; i < N; i++) c[i] = m[i][id];
    return c;
  endfunction

  always_comb begin
    kind     = conf_kind_e'(cfl_kind);
    cfl_ok   = cfl_vld && kind != CK_RSVD && live_q[cfl_src] &&
               live_q[cfl_dst] && cfl_src != cfl_dst;
    cyc_hit  = cfl_ok && !src_first;
    edge_add = cfl_ok && src_first;
    fwd_add  = edge_add && kind == CK_WR_RD;

    fwd_eff = fwd_q;
    if (fwd_add) fwd_eff[cfl_dst][cfl_src] = 1'b1;

    seed = '0;
    if (abt_vld && live_q[abt_id]) seed = seed | onehot(abt_id);
    if (cyc_hit)                   seed = seed | onehot(cfl_src);
    if (ovw_vld && live_q[ovw_id]) seed = seed | column(fwd_eff, ovw_id);
  end

  tdt_cascade #(.N(N)) u_cascade (
    .seed   (seed),
    .fwd    (fwd_eff),
    .doomed (doomed)
  );

  always_comb begin
    kill_c = doomed & live_q;
    blk    = edge_add ? onehot(cfl_dst) : '0;
    for (int i = 0; i < N; i++) pending[i] = |dep_q[i];
    commit_c = creq & live_q & ~kill_c & ~blk & ~pending;
    stall_c  = creq & live_q & ~kill_c & ~commit_c;
    leave    = commit_c | kill_c;
    join_vld = beg_vld && !live_q[beg_id];
  end

  always_comb begin
    dep_d = dep_q;
    fwd_d = fwd_eff;
    if (edge_add) dep_d[cfl_dst][cfl_src] = 1'b1;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (leave[i] || leave[j]) begin
          dep_d[i][j] = 1'b0;
          fwd_d[i][j] = 1'b0;
        end
      end
    end
    live_d = (live_q & ~leave) | (join_vld ? onehot(beg_id) : '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q   <= '0;
      dep_q    <= '0;
      fwd_q    <= '0;
      grant_o  <= '0;
      stall_o  <= '0;
      kill_o   <= '0;
      cyc_o    <= 1'b0;
      victim_o <= '0;
    end else begin
      live_q   <= live_d;
      dep_q    <= dep_d;
      fwd_q    <= fwd_d;
      grant_o  <= commit_c;
      stall_o  <= stall_c;
      kill_o   <= kill_c;
      cyc_o    <= cyc_hit;
      victim_o <= cyc_hit ? cfl_src : '0;
    end
  end

  assign live_o = live_q;

  // R10: never grant and abort the same slot together
  a_r10_grant_kill_disjoint: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o & kill_o) == '0);

  // R8: a reported victim is in the abort vector
  a_r8_victim_killed: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_o |-> kill_o[victim_o]);

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    // R3: a grant always answers a request from the previous cycle
    a_r3_grant_follows_request: assert property (@(posedge clk) disable iff (!rst_n)
      grant_o[gi] |-> $past(creq[gi]));
    // R4: a slot is never granted and stalled together
    a_r4_grant_or_stall: assert property (@(posedge clk) disable iff (!rst_n)
      !(grant_o[gi] && stall_o[gi]));
    for (genvar gj = 0; gj < N; gj++) begin : g_col
      // R5: edges only join live slots
      a_r5_edge_ends_live: assert property (@(posedge clk) disable iff (!rst_n)
        dep_q[gi][gj] |-> (live_q[gi] && live_q[gj]));
      // R6: every data-passing edge is also an ordering edge
      a_r6_fwd_within_dep: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_q[gi][gj] |-> dep_q[gi][gj]);
    end
  end

endmodule

// File: rtl/txn_order_tracker.sv
module txn_order_tracker #(
  parameter int N  = 4,
  parameter int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          beg_vld,
  input  logic [IW-1:0] beg_id,
  input  logic          cfl_vld,
  input  logic [IW-1:0] cfl_src,
  input  logic [IW-1:0] cfl_dst,
  input  logic [1:0]    cfl_kind,
  input  logic          ovw_vld,
  input  logic [IW-1:0] ovw_id,
  input  logic          abt_vld,
  input  logic [IW-1:0] abt_id,
  input  logic [N-1:0]  creq,
  output logic [N-1:0]  grant,
  output logic [N-1:0]  stall,
  output logic [N-1:0]  kill,
  output logic          cyc_flag,
  output logic [IW-1:0] cyc_victim
);

  logic          src_first;
  logic [N-1:0]  leave, occ, live;
  logic          join_vld;

  tdt_order #(.N(N), .IW(IW)) u_order (
    .clk     (clk),
    .rst_n   (rst_n),
    .drop    (leave),
    .add_vld (join_vld),
    .add_id  (beg_id),
    .qa      (cfl_src),
    .qb      (cfl_dst),
    .a_first (src_first),
    .occ     (occ)
  );

  tdt_graph #(.N(N), .IW(IW)) u_graph (
    .clk       (clk),
    .rst_n     (rst_n),
    .beg_vld   (beg_vld),
    .beg_id    (beg_id),
    .cfl_vld   (cfl_vld),
    .cfl_src   (cfl_src),
    .cfl_dst   (cfl_dst),
    .cfl_kind  (cfl_kind),
    .ovw_vld   (ovw_vld),
    .ovw_id    (ovw_id),
    .abt_vld   (abt_vld),
    .abt_id    (abt_id),
    .creq      (creq),
    .src_first (src_first),
    .leave     (leave),
    .join_vld  (join_vld),
    .live_o    (live),
    .grant_o   (grant),
    .stall_o   (stall),
    .kill_o    (kill),
    .cyc_o     (cyc_flag),
    .victim_o  (cyc_victim)
  );

  // R2: the order list holds exactly the live slots
  a_r2_order_matches_live: assert property (@(posedge clk) disable iff (!rst_n)
    occ == live);

endmodule

// File: tb/txn_order_tracker_test.sv
`timescale 1ns/1ps
module txn_order_tracker_test;

  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       beg_vld, cfl_vld, ovw_vld, abt_vld;
  logic [1:0] beg_id, cfl_src, cfl_dst, cfl_kind, ovw_id, abt_id;
  logic [N-1:0] creq, grant, stall, kill;
  logic       cyc_flag;
  logic [1:0] cyc_victim;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  txn_order_tracker uut (
    .clk(clk), .rst_n(rst_n),
    .beg_vld(beg_vld), .beg_id(beg_id),
    .cfl_vld(cfl_vld), .cfl_src(cfl_src), .cfl_dst(cfl_dst), .cfl_kind(cfl_kind),
    .ovw_vld(ovw_vld), .ovw_id(ovw_id),
    .abt_vld(abt_vld), .abt_id(abt_id),
    .creq(creq),
    .grant(grant), .stall(stall), .kill(kill),
    .cyc_flag(cyc_flag), .cyc_victim(cyc_victim)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, got, exp);
    end
  endtask

  task automatic idle();
    beg_vld = 0; beg_id = 0; cfl_vld = 0; cfl_src = 0; cfl_dst = 0; cfl_kind = 0;
    ovw_vld = 0; ovw_id = 0; abt_vld = 0; abt_id = 0; creq = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_begin(input logic [1:0] id);
    beg_vld = 1; beg_id = id; step(); idle();
  endtask

  task automatic do_cfl(input logic [1:0] s, input logic [1:0] d, input logic [1:0] k);
    cfl_vld = 1; cfl_src = s; cfl_dst = d; cfl_kind = k; step(); idle();
  endtask

  task automatic do_abort(input logic [1:0] id);
    abt_vld = 1; abt_id = id; step(); idle();
  endtask

  task automatic do_req(input logic [N-1:0] m);
    creq = m; step(); idle();
  endtask

  task automatic clean();
    for (int i = 0; i < N; i++) do_abort(2'(i));
    step();
  endtask

  task automatic t_reset();
    chk("R1", "grant", grant, 0);
    chk("R1", "stall", stall, 0);
    chk("R1", "kill", kill, 0);
    chk("R1", "cyc_flag", cyc_flag, 0);
    do_req(4'b1111);
    chk("R1", "grant idle", grant, 0);
    chk("R1", "stall idle", stall, 0);
  endtask

  task automatic t_simple_commit();
    do_begin(0);
    do_req(4'b0001);
    chk("R3", "grant", grant, 4'b0001);
    do_req(4'b0001);
    chk("R3", "slot freed", grant, 0);
  endtask

  task automatic t_begin_dup();
    do_begin(1); do_begin(2); do_begin(1);
    do_cfl(1, 2, 2'd0);
    chk("R2", "no cycle after dup begin", cyc_flag, 0);
    do_req(4'b0110);
    chk("R2", "grant first", grant, 4'b0010);
    chk("R2", "stall second", stall, 4'b0100);
    do_req(4'b0100);
    chk("R2", "grant second", grant, 4'b0100);
    clean();
  endtask

  task automatic t_order_stall();
    do_begin(0); do_begin(1); do_begin(2); do_begin(3);
    do_cfl(0, 1, 2'd0);
    do_cfl(2, 3, 2'd2);
    do_req(4'b0011);
    chk("R4", "grant pred", grant, 4'b0001);
    chk("R4", "stall succ", stall, 4'b0010);
    do_req(4'b0010);
    chk("R4", "grant after pred", grant, 4'b0010);
    do_abort(2);
    chk("R5", "ww no cascade", kill, 4'b0100);
    do_req(4'b1000);
    chk("R5", "dst freed", grant, 4'b1000);
    clean();
  endtask

  task automatic t_cascade();
    do_begin(0); do_begin(1); do_begin(2);
    do_cfl(0, 1, 2'd1);
    do_cfl(1, 2, 2'd1);
    do_abort(0);
    chk("R6", "chain kill", kill, 4'b0111);
    do_req(4'b0111);
    chk("R6", "chain gone", grant, 0);
    clean();
  endtask

  task automatic t_overwrite();
    do_begin(0); do_begin(1); do_begin(2);
    do_cfl(0, 1, 2'd1);
    do_cfl(0, 2, 2'd0);
    ovw_vld = 1; ovw_id = 0; step(); idle();
    chk("R7", "consumer killed", kill, 4'b0010);
    do_req(4'b0101);
    chk("R7", "producer lives", grant, 4'b0001);
    chk("R7", "reader waits", stall, 4'b0100);
    do_req(4'b0100);
    chk("R7", "reader granted", grant, 4'b0100);
    clean();
  endtask

  task automatic t_cycle();
    do_begin(0); do_begin(1); do_begin(2);
    do_cfl(1, 2, 2'd1);
    do_cfl(1, 0, 2'd2);
    chk("R8", "cyc_flag", cyc_flag, 1);
    chk("R8", "victim", cyc_victim, 1);
    chk("R8", "victim and receiver", kill, 4'b0110);
    step();
    chk("R8", "flag one cycle", cyc_flag, 0);
    do_req(4'b0001);
    chk("R8", "edge dropped", grant, 4'b0001);
    clean();
  endtask

  task automatic t_ignore();
    do_begin(0); do_begin(1);
    do_cfl(0, 3, 2'd0);
    chk("R9", "inactive dst", cyc_flag, 0);
    do_cfl(1, 1, 2'd2);
    chk("R9", "self edge", cyc_flag, 0);
    do_cfl(1, 0, 2'd3);
    chk("R9", "reserved kind cyc", cyc_flag, 0);
    chk("R9", "reserved kind kill", kill, 0);
    do_req(4'b0011);
    chk("R9", "both free", grant, 4'b0011);
    clean();
  endtask

  task automatic t_same_cycle();
    do_begin(0); do_begin(1);
    creq = 4'b0010; cfl_vld = 1; cfl_src = 0; cfl_dst = 1; cfl_kind = 2'd0;
    step(); idle();
    chk("R10", "dst blocked grant", grant, 0);
    chk("R10", "dst blocked stall", stall, 4'b0010);
    creq = 4'b0010; abt_vld = 1; abt_id = 1; step(); idle();
    chk("R10", "abort beats commit", grant, 0);
    chk("R10", "abort kill", kill, 4'b0010);
    chk("R10", "abort no stall", stall, 0);
    do_req(4'b0001);
    chk("R10", "pred grant", grant, 4'b0001);
    clean();
  endtask

  initial begin
    #(8 * 50000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_simple_commit();
    t_begin_dup();
    t_order_stall();
    t_cascade();
    t_overwrite();
    t_cycle();
    t_ignore();
    t_same_cycle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule